// File: doc/BRIEF.md
# Per-pin input glitch and debounce filter bank

This block conditions the synchronized levels of a bank of input pins before they reach the pin-data status. Each pin has its own filter, which is either bypassed or active. An active filter runs in one of two modes. Glitch mode counts system clock edges. Debounce mode counts pulses of a slow tick that one programmable divider makes for the whole bank. A pin whose filter is off passes its input straight to its output, with no register on the way.

Software configures the bank through a single write strobe with a 3-bit address and a data word. The enable state and the mode state each have one address that sets bits and one that clears bits, so that one pin can be changed without a read-modify-write. The divider has its own address. The register contents come out on plain status pins. The pin inputs and the filtered outputs are plain level signals with no handshake. Every cycle carries a new sample, so no back-pressure applies.

Top module: `pinflt_bank`

## Requirements
- R1: After reset, every filter is disabled, every pin is in glitch mode (`filt_dbn` bit 0), `div_val` is 0 and `pin_out` equals `pin_in`.
- R2: A write to address 0 sets `filt_en` bits where the data has 1s, and a write to address 1 clears them. Bits where the data is 0 are left unchanged.
- R3: A write to address 3 sets `filt_dbn` bits (debounce mode, encoded 1), and a write to address 2 clears them (glitch mode, encoded 0). The mode bit changes the same way whether the filter is on or off, and the enable bit does not change.
- R4: A write to address 4 stores data bits 13:0 into `div_val`, ignores all higher bits, and restarts the divider count at zero.
- R5: The slow tick pulses once every 2*(div+1) clock cycles. After a divider write, the first tick is consumed at the 2*(div+1)-th rising edge following the write edge.
- R6: While a pin's filter is disabled, its `pin_out` bit equals its `pin_in` bit in the same cycle.
- R7: In glitch mode, a level that differs from the filtered output must be sampled at 2 consecutive rising edges, and the output takes it after the second of them. A level that lasts 1 cycle never appears.
- R8: In debounce mode, the differing level must be present at 2 consecutive ticks. Any sample equal to the filtered output restarts the count.
- R9: Enabling a filter starts it from the current input level, so a steady input gives no change on `pin_out`.
- R10: Writes to addresses 5, 6 and 7 change no register.
- R11: Disabling a filter partway through a count returns the pin to direct pass-through at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_in | input | 32 | Synchronized pad levels |
| pin_out | output | 32 | Filtered pin levels |
| filt_en | output | 32 | Filter enable state per pin |
| filt_dbn | output | 32 | Mode per pin, 1 = debounce |
| div_val | output | 14 | Divider value |

## Verification
The assertions check the following on every cycle: each set, clear and divider write lands one cycle later, disabled pins pass through unchanged, no two ticks come back to back, and an active filter moves its output only to a level that was sampled on the two previous edges (glitch mode) or only on an edge where a tick was consumed (debounce mode). The exact settling times can only be shown by the bench's scenarios. These are the output edge at 2*(div+1)*2 cycles after a divider write, the delay caused by a one-cycle drop in debounce mode, the pulse-width sweep over every pin, and the smooth handover when a filter is switched on or off.

// File: rtl/pinflt_pkg.sv
package pinflt_pkg;
  typedef enum logic [2:0] {
    A_EN_SET = 3'd0,
    A_EN_CLR = 3'd1,
    A_SEL_GL = 3'd2,
    A_SEL_DB = 3'd3,
    A_DIV    = 3'd4
  } cfg_addr_e;
endpackage

// File: rtl/pinflt_cfg.sv
module pinflt_cfg import pinflt_pkg::*; #(
  parameter int NPINS = 32,
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_addr,
  input  logic [NPINS-1:0] cfg_wdata,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] dbn_q,
  output logic [DIV_W-1:0] div_q,
  output logic             div_restart
);
  cfg_addr_e addr_dec;
  assign addr_dec    = cfg_addr_e'(cfg_addr);
  assign div_restart = cfg_wr && (addr_dec == A_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      dbn_q <= '0;
      div_q <= '0;
    end else if (cfg_wr) begin
      case (addr_dec)
        A_EN_SET: en_q  <= en_q | cfg_wdata;
        A_EN_CLR: en_q  <= en_q & ~cfg_wdata;
        A_SEL_GL: dbn_q <= dbn_q & ~cfg_wdata;
        A_SEL_DB: dbn_q <= dbn_q | cfg_wdata;
        A_DIV:    div_q <= cfg_wdata[DIV_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pinflt_tick.sv
module pinflt_tick #(
  parameter int DIV_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // limit = 2*div + 1, so one period spans 2*(div+1) cycles
  assign limit = {div, 1'b1};
  assign tick  = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pinflt_cell.sv
module pinflt_cell #(
  parameter int STABLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dbn,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;
  logic          lvl_q;
  logic [CW-1:0] run_q;
  logic          step;

  assign step = dbn ? tick : 1'b1;
  assign dout = en ? lvl_q : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (!en) begin
      lvl_q <= din;          // track the input so enabling starts in step
      run_q <= '0;
    end else if (din == lvl_q) begin
      run_q <= '0;           // any return to the held level restarts
    end else if (step) begin
      if (run_q == CW'(STABLE - 1)) begin
        lvl_q <= din;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pinflt_bank.sv
module pinflt_bank import pinflt_pkg::*; #(
  parameter int NPINS  = 32,
  parameter int DIV_W  = 14,
  parameter int STABLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_addr,
  input  logic [NPINS-1:0] cfg_wdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] filt_en,
  output logic [NPINS-1:0] filt_dbn,
  output logic [DIV_W-1:0] div_val
);
  logic div_restart;
  logic tick_w;

  pinflt_cfg #(.NPINS(NPINS), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en_q(filt_en), .dbn_q(filt_dbn),
    .div_q(div_val), .div_restart(div_restart)
  );

  pinflt_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_val), .restart(div_restart),
    .tick(tick_w)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pinflt_cell #(.STABLE(STABLE)) u_cell (
      .clk(clk), .rst_n(rst_n), .en(filt_en[i]), .dbn(filt_dbn[i]),
      .tick(tick_w), .din(pin_in[i]), .dout(pin_out[i])
    );
  end
endmodule

// File: rtl/pinflt_bank_chk.sv
module pinflt_bank_chk #(
  parameter int NPINS = 32,
  parameter int DIV_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [2:0]       cfg_addr,
  input logic [NPINS-1:0] cfg_wdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] filt_en,
  input logic [NPINS-1:0] filt_dbn,
  input logic [DIV_W-1:0] div_val,
  input logic             tick
);
  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 3'd0) |=> ((filt_en & $past(cfg_wdata)) == $past(cfg_wdata)));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 3'd1) |=> ((filt_en & $past(cfg_wdata)) == '0));
  // R3
  sel_db_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 3'd3) |=> ((filt_dbn & $past(cfg_wdata)) == $past(cfg_wdata)));
  // R3
  sel_gl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 3'd2) |=> ((filt_dbn & $past(cfg_wdata)) == '0));
  // R4
  div_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 3'd4) |=> (div_val == $past(cfg_wdata[DIV_W-1:0])));
  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ pin_in) & ~filt_en) == '0);
  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R7
  glitch_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ $past(pin_out)) & filt_en & ~filt_dbn & $past(filt_en & ~filt_dbn)
      & ((pin_out ^ $past(pin_in)) | (pin_out ^ $past(pin_in, 2)))) == '0);
  // R8
  dbn_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_out ^ $past(pin_out)) & filt_en & filt_dbn & $past(filt_en & filt_dbn)) != '0)
      |-> $past(tick));
endmodule

bind pinflt_bank pinflt_bank_chk #(.NPINS(NPINS), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .pin_in(pin_in), .pin_out(pin_out),
  .filt_en(filt_en), .filt_dbn(filt_dbn), .div_val(div_val), .tick(tick_w)
);

// File: tb/pinflt_bank_test.sv
module pinflt_bank_test;
  localparam int CLK_P = 10;
  localparam int N     = 32;
  localparam int DW    = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [N-1:0]  cfg_wdata = '0;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, filt_en, filt_dbn;
  logic [DW-1:0] div_val;
  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  pinflt_bank uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_in(pin_in), .pin_out(pin_out),
    .filt_en(filt_en), .filt_dbn(filt_dbn), .div_val(div_val)
  );

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present a write for one rising edge; returns at the following negedge
  task automatic wcfg(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // debounce run on pin 5: output must rise after edge 2*P (or 3*P with a drop)
  task automatic db_run(input int d, input bit drop);
    int p;
    int rise;
    logic [N-1:0] e;
    p = 2 * (d + 1);
    rise = drop ? 3 * p : 2 * p;
    wcfg(3'd4, N'(d));
    pin_in[5] = 1'b1;
    for (int k = 1; k <= rise + 1; k++) begin
      @(negedge clk);
      e = '0;
      e[5] = (k >= rise);
      chk(pin_out == e, drop ? "R8 restart" : "R5/R8 debounce", pin_out, e);
      if (drop && k == p)     pin_in[5] = 1'b0;
      if (drop && k == p + 1) pin_in[5] = 1'b1;
    end
    pin_in[5] = 1'b0;
    idle(3 * p + 2);
    chk(pin_out == '0, "R8 release", pin_out, '0);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] e;
    pin_in = 32'h1234_5678;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(pin_out == pin_in, "R1 out", pin_out, pin_in);
    chk(filt_en == '0, "R1 en", filt_en, '0);
    chk(filt_dbn == '0, "R1 mode", filt_dbn, '0);
    chk(N'(div_val) == '0, "R1 div", N'(div_val), '0);

    // R6 pass-through sweep with walking ones and zeros
    for (int i = 0; i < N; i++) begin
      pin_in = N'(1) << i; #1;
      chk(pin_out == pin_in, "R6 walk1", pin_out, pin_in);
      pin_in = ~(N'(1) << i); #1;
      chk(pin_out == pin_in, "R6 walk0", pin_out, pin_in);
    end

    // R2 enable set/clear
    pin_in = '0;
    wcfg(3'd0, 32'h0000_00FF);
    chk(filt_en == 32'h0000_00FF, "R2 set", filt_en, 32'h0000_00FF);
    wcfg(3'd0, 32'hF000_0000);
    chk(filt_en == 32'hF000_00FF, "R2 set keep", filt_en, 32'hF000_00FF);
    wcfg(3'd1, 32'h0000_000F);
    chk(filt_en == 32'hF000_00F0, "R2 clr", filt_en, 32'hF000_00F0);
    wcfg(3'd1, '1);
    chk(filt_en == '0, "R2 clr all", filt_en, '0);

    // R3 mode select while disabled
    wcfg(3'd3, 32'h0000_0F0F);
    chk(filt_dbn == 32'h0000_0F0F, "R3 sel db", filt_dbn, 32'h0000_0F0F);
    wcfg(3'd2, 32'h0000_0003);
    chk(filt_dbn == 32'h0000_0F0C, "R3 sel gl", filt_dbn, 32'h0000_0F0C);
    chk(filt_en == '0, "R3 en untouched", filt_en, '0);
    pin_in = 32'h0000_0F00; #1;
    chk(pin_out == pin_in, "R3 still bypass", pin_out, pin_in);
    wcfg(3'd2, '1);
    chk(filt_dbn == '0, "R3 gl all", filt_dbn, '0);

    // R10 unused addresses
    for (int a = 5; a < 8; a++) begin
      wcfg(3'(a), '1);
      chk(filt_en == '0 && filt_dbn == '0 && div_val == '0, "R10 ignored",
          filt_en | filt_dbn | N'(div_val), '0);
    end

    // R4 divider field mask
    wcfg(3'd4, '1);
    chk(N'(div_val) == 32'h0000_3FFF, "R4 mask", N'(div_val), 32'h0000_3FFF);

    // R9 enable from the current level
    pin_in = 32'hA5A5_0F0F;
    idle(2);
    wcfg(3'd0, '1);
    for (int k = 0; k < 3; k++) begin
      chk(pin_out == 32'hA5A5_0F0F, "R9 seamless", pin_out, 32'hA5A5_0F0F);
      @(negedge clk);
    end
    pin_in = '0;
    idle(4);
    chk(pin_out == '0, "R7 settle low", pin_out, '0);

    // R7 glitch pulse-width sweep on every pin
    for (int p = 0; p < N; p++) begin
      for (int w = 1; w <= 3; w++) begin
        pin_in[p] = 1'b1;
        for (int k = 1; k <= w + 3; k++) begin
          @(negedge clk);
          e = '0;
          e[p] = (w >= 2) && (k >= 2) && (k <= w + 1);
          chk(pin_out == e, "R7 glitch", pin_out, e);
          if (k == w) pin_in[p] = 1'b0;
        end
      end
    end

    // R11 disable partway through a count
    pin_in[7] = 1'b1;
    wcfg(3'd1, 32'h0000_0080);
    e = '0; e[7] = 1'b1;
    chk(pin_out == e, "R11 bypass now", pin_out, e);
    pin_in[7] = 1'b0; #1;
    chk(pin_out == '0, "R11 follows", pin_out, '0);

    // R5 / R8 debounce on pin 5
    wcfg(3'd3, 32'h0000_0020);
    idle(2);
    db_run(0, 1'b0);
    db_run(1, 1'b0);
    db_run(3, 1'b0);
    db_run(1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule